// File: doc/BRIEF.md
# Daisy-Chain Serial Configuration Receiver

This block is the receiving end of a serial configuration link inside one device of a chain of programmable devices. Every device in the chain shares one configuration clock. Each device samples its serial input on the rising edge. It passes what it receives to the next device on a falling-edge output, so each downstream stage has half a clock period of timing margin.

The block watches the incoming stream for a four-bit sync pattern. It then captures a 24-bit length count, which it also forwards down the chain. Next it takes its own fixed number of frames, each marked by a zero start bit, and writes each frame through a simple write port. While it does this it drives its chain output high. After its own frames it becomes transparent and relays every later bit.

Separately, the block counts configuration clocks from the moment reset is released. It raises done when that count reaches the captured length. Because every device sees the same clock and the same length, the whole chain reaches done together. I/O release follows two clocks after done. An active-low program input restarts everything.

Top module: `cfg_chain_rx`

## Requirements
- R1: While prog_n is low, dout is 1 and done, io_release and wr_en are 0. Reset assertion acts at once. Release is synchronised, so the first counted ("active") rising edge is the third rising edge of cfg_clk after prog_n goes high.
- R2: din is sampled on the rising edge of cfg_clk. dout changes only on the falling edge, where it takes the value chosen for the bit sampled on the preceding rising edge. Just after a rising edge, dout still shows the previous bit.
- R3: Until the length count has been fully received, dout repeats every sampled bit. This covers idle bits, the sync pattern and all length bits.
- R4: The sync pattern is found on the first active edge where the last four sampled bits, oldest first, are 0,0,1,0. Bits before that, including idle 1s and partial patterns, cause no frame write.
- R5: The 24 bits right after the sync pattern form the length count, most significant bit first.
- R6: From the bit after the last length bit until the last data bit of the device's final frame, dout is 1 whatever din carries.
- R7: Each frame starts with a 0 start bit, and 1s while waiting for a start bit are ignored. FRAME_BITS data bits follow the start bit. The first data bit received is the MSB of wr_data. wr_en is a one-cycle pulse that is visible after the edge that samples the last data bit. wr_addr counts frames from 0.
- R8: After NUM_FRAMES frames, dout repeats every later bit, zeros included, with no further frame decoding.
- R9: done rises after active edge N, where N equals the captured length count. It then stays high until reset.
- R10: io_release rises exactly two active edges after done rises, and is never high without done.
- R11: Pulling prog_n low in mid-stream abandons the load. After release, the block searches for the sync pattern again and numbers frames from 0 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_clk | input | 1 | Shared configuration clock |
| prog_n | input | 1 | Active-low program/reset, asynchronous assert |
| din | input | 1 | Serial configuration data in |
| dout | output | 1 | Chain output to next device, falling-edge timed |
| wr_en | output | 1 | Frame write strobe, one cycle |
| wr_addr | output | clog2(NUM_FRAMES) | Index of the frame being written |
| wr_data | output | FRAME_BITS | Frame payload, first bit in MSB |
| done | output | 1 | Configuration clock count reached the length count |
| io_release | output | 1 | User I/O release, two clocks after done |

## Verification
The assertions check several rules on every clock: done is sticky, done rises only when the clock counter equals the captured length, io_release lags done by exactly two edges, write pulses are single and stay inside the frame range, and the load phase begins only after a complete length capture. Some behaviour only the directed scenarios can show. This includes the bit-exact content of dout through the header, hold and pass phases, and the half-period output timing. It also includes sync detection after misleading prefixes, the payload bit order and address of each frame, idle bits between frames, and a restart after a mid-load program pulse.

// File: rtl/cfg_chain_pkg.sv
package cfg_chain_pkg;
  typedef enum logic [1:0] {
    ST_SEARCH,
    ST_LENGTH,
    ST_LOAD,
    ST_PASS
  } rx_state_e;

  // oldest bit first
  localparam logic [3:0] SYNC_WORD = 4'b0010;
endpackage

// File: rtl/cfg_rst_sync.sv
module cfg_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_out
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_n_out = s2_q;
endmodule

// File: rtl/cfg_frame_loader.sv
module cfg_frame_loader #(
  parameter int FRAME_BITS = 8,
  parameter int NUM_FRAMES = 3,
  localparam int IDX_W = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1,
  localparam int BIT_W = (FRAME_BITS > 2) ? $clog2(FRAME_BITS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en,
  input  logic                  din,
  output logic                  wr_en,
  output logic [IDX_W-1:0]      wr_addr,
  output logic [FRAME_BITS-1:0] wr_data,
  output logic                  load_end
);
  logic                  in_frame_q, in_frame_d;
  logic [BIT_W-1:0]      bit_q, bit_d;
  logic [IDX_W-1:0]      frm_q, frm_d;
  logic [FRAME_BITS-1:0] shf_q, shf_d;
  logic                  wr_en_q, wr_en_d;
  logic [IDX_W-1:0]      wr_addr_q, wr_addr_d;
  logic [FRAME_BITS-1:0] wr_data_q, wr_data_d;
  logic                  last_bit;

  assign last_bit = in_frame_q && (bit_q == BIT_W'(FRAME_BITS - 1));
  assign load_end = en && last_bit && (frm_q == IDX_W'(NUM_FRAMES - 1));

  always_comb begin
    in_frame_d = in_frame_q;
    bit_d      = bit_q;
    frm_d      = frm_q;
    shf_d      = shf_q;
    wr_en_d    = 1'b0;
    wr_addr_d  = wr_addr_q;
    wr_data_d  = wr_data_q;
    if (en) begin
      if (!in_frame_q) begin
        if (!din) begin
          in_frame_d = 1'b1;
          bit_d      = '0;
        end
      end else begin
        shf_d = {shf_q[FRAME_BITS-2:0], din};
        if (last_bit) begin
          in_frame_d = 1'b0;
          wr_en_d    = 1'b1;
          wr_addr_d  = frm_q;
          wr_data_d  = shf_d;
          frm_d      = frm_q + 1'b1;
        end else begin
          bit_d = bit_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame_q <= 1'b0;
      bit_q      <= '0;
      frm_q      <= '0;
      shf_q      <= '0;
      wr_en_q    <= 1'b0;
      wr_addr_q  <= '0;
      wr_data_q  <= '0;
    end else begin
      in_frame_q <= in_frame_d;
      bit_q      <= bit_d;
      frm_q      <= frm_d;
      shf_q      <= shf_d;
      wr_en_q    <= wr_en_d;
      wr_addr_q  <= wr_addr_d;
      wr_data_q  <= wr_data_d;
    end
  end

  assign wr_en   = wr_en_q;
  assign wr_addr = wr_addr_q;
  assign wr_data = wr_data_q;

  AST_WR_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_q |-> (int'(wr_addr_q) < NUM_FRAMES)); // R7
  AST_WR_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_q |=> !wr_en_q); // R7
endmodule

// File: rtl/cfg_dout_resync.sv
module cfg_dout_resync (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b1;
    else        q <= d;
  end
endmodule

// File: rtl/cfg_chain_rx.sv
module cfg_chain_rx
  import cfg_chain_pkg::*;
#(
  parameter int FRAME_BITS = 8,
  parameter int NUM_FRAMES = 3,
  parameter int LEN_BITS   = 24
) (
  input  logic                                                cfg_clk,
  input  logic                                                prog_n,
  input  logic                                                din,
  output logic                                                dout,
  output logic                                                wr_en,
  output logic [((NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1)-1:0] wr_addr,
  output logic [FRAME_BITS-1:0]                               wr_data,
  output logic                                                done,
  output logic                                                io_release
);
  localparam int LCNT_W = $clog2(LEN_BITS);

  logic              rst_n;
  rx_state_e         state_q, state_d;
  logic [2:0]        win_q, win_d;
  logic [LCNT_W-1:0] lcnt_q, lcnt_d;
  logic [LEN_BITS-1:0] len_q, len_d;
  logic              len_vld_q, len_vld_d;
  logic [LEN_BITS-1:0] clk_cnt_q, clk_cnt_d;
  logic              done_q, done_d;
  logic [1:0]        rel_q, rel_d;
  logic              pass_q, pass_d;
  logic              load_en, load_end;

  cfg_rst_sync u_rst (
    .clk       (cfg_clk),
    .arst_n    (prog_n),
    .rst_n_out (rst_n)
  );

  assign load_en = (state_q == ST_LOAD);

  cfg_frame_loader #(
    .FRAME_BITS (FRAME_BITS),
    .NUM_FRAMES (NUM_FRAMES)
  ) u_loader (
    .clk      (cfg_clk),
    .rst_n    (rst_n),
    .en       (load_en),
    .din      (din),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .load_end (load_end)
  );

  always_comb begin
    state_d   = state_q;
    win_d     = win_q;
    lcnt_d    = lcnt_q;
    len_d     = len_q;
    len_vld_d = len_vld_q;
    unique case (state_q)
      ST_SEARCH: begin
        win_d = {win_q[1:0], din};
        if ({win_q, din} == SYNC_WORD) begin
          state_d = ST_LENGTH;
          lcnt_d  = '0;
        end
      end
      ST_LENGTH: begin
        len_d = {len_q[LEN_BITS-2:0], din};
        if (lcnt_q == LCNT_W'(LEN_BITS - 1)) begin
          len_vld_d = 1'b1;
          state_d   = ST_LOAD;
        end else begin
          lcnt_d = lcnt_q + 1'b1;
        end
      end
      ST_LOAD: begin
        if (load_end) state_d = ST_PASS;
      end
      default: ;
    endcase
    pass_d    = load_en ? 1'b1 : din;
    clk_cnt_d = (&clk_cnt_q) ? clk_cnt_q : clk_cnt_q + 1'b1;
    done_d    = done_q | (len_vld_q && (clk_cnt_d == len_q));
    rel_d     = {rel_q[0], done_q};
  end

  always_ff @(posedge cfg_clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_SEARCH;
      win_q     <= 3'b111;
      lcnt_q    <= '0;
      len_q     <= '0;
      len_vld_q <= 1'b0;
      clk_cnt_q <= '0;
      done_q    <= 1'b0;
      rel_q     <= 2'b00;
      pass_q    <= 1'b1;
    end else begin
      state_q   <= state_d;
      win_q     <= win_d;
      lcnt_q    <= lcnt_d;
      len_q     <= len_d;
      len_vld_q <= len_vld_d;
      clk_cnt_q <= clk_cnt_d;
      done_q    <= done_d;
      rel_q     <= rel_d;
      pass_q    <= pass_d;
    end
  end

  cfg_dout_resync u_out (
    .clk   (cfg_clk),
    .rst_n (rst_n),
    .d     (pass_q),
    .q     (dout)
  );

  assign done       = done_q;
  assign io_release = rel_q[1];

  AST_LOAD_AFTER_LENGTH: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    (state_q == ST_LOAD) |-> len_vld_q); // R5
  AST_WR_ONLY_WHILE_LOADING: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    wr_en |-> $past(state_q == ST_LOAD)); // R7
  AST_DONE_STICKY: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    done_q |=> done_q); // R9
  AST_DONE_AT_COUNT: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    $rose(done_q) |-> (clk_cnt_q == len_q)); // R9
  AST_REL_NOT_EARLY: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    $rose(done_q) |=> !rel_q[1]); // R10
  AST_REL_AFTER_TWO: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    $rose(done_q) |=> ##1 rel_q[1]); // R10
  AST_REL_NEEDS_DONE: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    rel_q[1] |-> done_q); // R10
endmodule

// File: tb/sim_cfg_chain_rx.sv
module sim_cfg_chain_rx;
  localparam int FB = 8;
  localparam int NF = 3;
  localparam int LB = 24;
  localparam int AW = 2;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          prog_n, din;
  logic          dout, wr_en, done, io_release;
  logic [AW-1:0] wr_addr;
  logic [FB-1:0] wr_data;

  cfg_chain_rx #(.FRAME_BITS(FB), .NUM_FRAMES(NF), .LEN_BITS(LB)) u0 (
    .cfg_clk(clk), .prog_n(prog_n), .din(din), .dout(dout),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .done(done), .io_release(io_release)
  );

  int pass_cnt = 0;
  int fail_cnt = 0;
  int n_act, cur_len, frm_ctr, wr_seen, first_addr;
  logic prev_exp;
  bit   q_bit[$];
  int   q_phase[$];
  int   q_wr[$];
  logic [FB-1:0] q_wdata[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    if (ok) pass_cnt++;
    else begin
      fail_cnt++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clear_q();
    q_bit.delete(); q_phase.delete(); q_wr.delete(); q_wdata.delete();
    frm_ctr = 0; wr_seen = 0; first_addr = -1;
  endtask

  // phase 0: header forward, 1: own load (held high), 2: overflow forward
  task automatic add_bits(input logic [31:0] v, input int nb, input int ph);
    for (int i = nb - 1; i >= 0; i--) begin
      q_bit.push_back(v[i]); q_phase.push_back(ph);
      q_wr.push_back(-1); q_wdata.push_back('0);
    end
  endtask

  task automatic add_frame(input logic [FB-1:0] d);
    add_bits(32'd0, 1, 1);
    for (int i = FB - 1; i >= 0; i--) begin
      q_bit.push_back(d[i]); q_phase.push_back(1);
      q_wr.push_back(i == 0 ? frm_ctr : -1); q_wdata.push_back(d);
    end
    frm_ctr++;
  endtask

  task automatic do_reset();
    @(negedge clk); #1;
    prog_n = 1'b0; din = 1'b1;
    #20;
    chk(dout == 1'b1, "R1", "dout in reset", dout, 1);
    chk(done == 1'b0 && io_release == 1'b0, "R1", "done/io in reset",
        {done, io_release}, 0);
    chk(wr_en == 1'b0, "R1", "wr_en in reset", wr_en, 0);
    @(negedge clk); #1;
    prog_n = 1'b1;
    for (int k = 0; k < 2; k++) begin
      @(negedge clk); #1;
    end
    n_act = 0; prev_exp = 1'b1;
  endtask

  task automatic play(input int from, input int upto);
    for (int i = from; i < upto; i++) begin
      logic exp;
      din = q_bit[i];
      @(posedge clk); #1;
      n_act++;
      chk(dout == prev_exp, "R2", "dout before falling edge", dout, prev_exp);
      if (q_wr[i] >= 0) begin
        chk(wr_en == 1'b1 && int'(wr_addr) == q_wr[i] && wr_data == q_wdata[i],
            "R7", "frame write", {wr_en, wr_addr, wr_data},
            {1'b1, AW'(q_wr[i]), q_wdata[i]});
        if (wr_seen == 0) first_addr = int'(wr_addr);
        wr_seen++;
      end else begin
        chk(wr_en == 1'b0, "R7", "no write", wr_en, 0);
      end
      chk(done == (n_act >= cur_len), "R9", "done vs clock count", done,
          n_act >= cur_len);
      chk(io_release == (n_act >= cur_len + 2), "R10", "io_release timing",
          io_release, n_act >= cur_len + 2);
      @(negedge clk); #1;
      exp = (q_phase[i] == 1) ? 1'b1 : q_bit[i];
      if (q_phase[i] == 0)      chk(dout == exp, "R3", "header forward", dout, exp);
      else if (q_phase[i] == 1) chk(dout == exp, "R6", "held high", dout, exp);
      else                      chk(dout == exp, "R8", "overflow forward", dout, exp);
      prev_exp = exp;
    end
  endtask

  task automatic scen_basic();
    clear_q(); cur_len = 80;
    add_bits(32'b111, 3, 0);
    add_bits(32'b0010, 4, 0);
    add_bits(32'd80, LB, 0);
    add_frame(8'hA5);
    add_bits(32'b11, 2, 1);
    add_frame(8'h3C);
    add_frame(8'hF0);
    add_bits(32'hB3A5C, 20, 2);
    add_bits(32'hF, 4, 2);
    do_reset();
    play(0, q_bit.size());
    chk(wr_seen == NF, "R7", "frames written", wr_seen, NF);
  endtask

  task automatic scen_false_sync();
    clear_q(); cur_len = 64;
    add_bits(32'b1101100010, 10, 0);
    add_bits(32'd64, LB, 0);
    add_frame(8'h00);
    add_frame(8'hFF);
    add_frame(8'h81);
    add_bits(32'b010, 3, 2);
    add_bits(32'h1F, 5, 2);
    do_reset();
    play(0, 63);
    chk(done == 1'b0, "R5", "length one short", done, 0);
    play(63, q_bit.size());
    chk(done == 1'b1, "R5", "length reached", done, 1);
    chk(wr_seen == NF, "R4", "sync found once, frames written", wr_seen, NF);
  endtask

  task automatic scen_restart();
    clear_q(); cur_len = 100;
    add_bits(32'b11, 2, 0);
    add_bits(32'b0010, 4, 0);
    add_bits(32'd100, LB, 0);
    add_frame(8'h5A);
    add_frame(8'hC3);
    do_reset();
    play(0, 43);
    prog_n = 1'b0;
    #1;
    chk(dout == 1'b1 && done == 1'b0 && io_release == 1'b0 && wr_en == 1'b0,
        "R11", "mid-stream program pulse", {dout, done, io_release, wr_en}, 4'b1000);
    clear_q(); cur_len = 60;
    add_bits(32'b0010, 4, 0);
    add_bits(32'd60, LB, 0);
    add_frame(8'h11);
    add_frame(8'h22);
    add_frame(8'h33);
    add_bits(32'h5, 5, 2);
    add_bits(32'hA, 4, 2);
    do_reset();
    play(0, q_bit.size());
    chk(first_addr == 0, "R11", "frame index restarts", first_addr, 0);
    chk(wr_seen == NF, "R11", "full reload after restart", wr_seen, NF);
  endtask

  initial begin
    prog_n = 1'b0; din = 1'b1;
    scen_basic();
    scen_false_sync();
    scen_restart();
    $display("%0d/%0d checks passed", pass_cnt, pass_cnt + fail_cnt);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fail_cnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", pass_cnt, pass_cnt + fail_cnt);
    $finish;
  end
endmodule